// File: doc/BRIEF.md
# Multi-line interrupt vector arbiter

This block gathers interrupt requests from a bank of serial lines and turns them into two master request outputs and a vector per acknowledge. Every line has three request bits: receive, dataset-change and transmit. Each bit is raised and lowered by one-cycle pulses. The receive and dataset-change bits of all lines feed the input-side master request. The transmit bits feed the output-side master request.

When the processor acknowledges a side, the block chooses the lowest-numbered line that has a request on that side and clears that line's bits for that side. It registers a vector from a programmable base. A line's receive and dataset-change requests share one vector slot. The transmit vector of the same line sits 4 above it. An acknowledge that finds nothing pending returns vector 0. The number of lines that exist is a parameter, and lines above that count never request.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset all request bits are clear, `in_irq`, `out_irq` and `vec_valid` are 0 and `vec_out` is 0.
- R2: A set pulse raises its request bit at the next clock edge. `in_irq` is the OR of every receive and dataset-change bit, and `out_irq` is the OR of every transmit bit.
- R3: An `in_ack` sampled at a clock edge selects the lowest line whose receive or dataset-change bit is set. At that edge it registers `vec_out` = aligned base + 8 × line and raises `vec_valid` for one cycle.
- R4: An input acknowledge clears both the receive and the dataset-change bit of the chosen line and nothing else. `in_irq` stays high while any other input-side bit remains set.
- R5: An `out_ack` selects the lowest line with a transmit bit set, clears only that bit and returns aligned base + 8 × line + 4. Input-side bits are untouched.
- R6: An acknowledge for a side with no pending bit returns `vec_out` = 0 with `vec_valid` high.
- R7: With `ACTIVE_LINES` = A, set pulses on lines A and above have no effect on any request or on either master request.
- R8: A set and a clear pulse for the same bit in the same cycle leave the bit set.
- R9: The line chosen by an acknowledge ends with that side's bits clear even if a set pulse for it arrives in the same cycle. Set pulses for other lines in that cycle are kept.
- R10: When `in_ack` and `out_ack` arrive in the same cycle, only the input side is served. The transmit bits are unchanged and stay pending for a later `out_ack`.
- R11: Bits [1:0] of `vec_base` are ignored. The base is used as `vec_base & 9'h1FC`, sampled at the acknowledge edge.
- R12: `vec_valid` is low in every cycle that follows a cycle without an acknowledge, and `vec_out` then holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_set | input | NLINES | Per-line receive request set pulses |
| rx_clr | input | NLINES | Per-line receive request clear pulses |
| ds_set | input | NLINES | Per-line dataset-change request set pulses |
| ds_clr | input | NLINES | Per-line dataset-change request clear pulses |
| tx_set | input | NLINES | Per-line transmit request set pulses |
| tx_clr | input | NLINES | Per-line transmit request clear pulses |
| vec_base | input | 9 | Vector base; the two low bits are ignored |
| in_ack | input | 1 | Input-side acknowledge strobe |
| out_ack | input | 1 | Output-side acknowledge strobe |
| in_irq | output | 1 | Input-side master request |
| out_irq | output | 1 | Output-side master request |
| vec_out | output | 10 | Vector registered at the last acknowledge |
| vec_valid | output | 1 | High for one cycle after an acknowledge |

## Verification
A stuck or lost request bit shows at the ports one cycle after its set or acknowledge edge. The master request stays high or low when it should not, or a later acknowledge returns a vector for the wrong line. A fault in the priority chain or the vector arithmetic shows in the `vec_out` of the very acknowledge that uses it. For that reason the tests keep several lines pending at once and drain them one acknowledge at a time, checking the master request after each one. Same-cycle collisions between set, clear and acknowledge are driven on purpose, because a wrong merge order only shows up in those cycles.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int LINE_MAX = 16;
  localparam int BASE_W   = 9;
  localparam int IDX_W    = 4;
  localparam int VEC_W    = 10;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_IN   = 2'd1,
    ACK_OUT  = 2'd2
  } ack_kind_e;

  // Base with its two low bits forced to zero (4-byte aligned).
  function automatic logic [VEC_W-1:0] aligned_base(input logic [BASE_W-1:0] base);
    return {1'b0, base[BASE_W-1:2], 2'b00};
  endfunction

  // Vector = aligned base + 8 * line, plus 4 for the transmit side.
  function automatic logic [VEC_W-1:0] vec_calc(input logic [BASE_W-1:0] base,
                                                input logic [IDX_W-1:0]  line,
                                                input logic              tx_side);
    logic [VEC_W-1:0] slot;
    logic [VEC_W-1:0] side_off;
    slot     = {3'b000, line, 3'b000};
    side_off = tx_side ? VEC_W'(4) : VEC_W'(0);
    return aligned_base(base) + slot + side_off;
  endfunction

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_arb_pkg::*;
#(
  parameter int NLINES       = 16,
  parameter int ACTIVE_LINES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] set_i,
  input  logic [NLINES-1:0] clr_i,
  input  logic [NLINES-1:0] ack_clr_i,
  output logic [NLINES-1:0] pend_o
);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (i < ACTIVE_LINES) begin : g_live
      logic pend_q;
      logic pend_d;

      // Acknowledge clear wins; otherwise set wins over clear.
      always_comb begin
        if (ack_clr_i[i])      pend_d = 1'b0;
        else if (set_i[i])     pend_d = 1'b1;
        else if (clr_i[i])     pend_d = 1'b0;
        else                   pend_d = pend_q;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
      end

      assign pend_o[i] = pend_q;

      // R8: a set not overridden by an acknowledge always lands
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[i] && !ack_clr_i[i]) |=> pend_o[i]);

      // R9: the acknowledged line is empty afterwards
      p_ack_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr_i[i] |=> !pend_o[i]);

      // R2: with no event the bit holds
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i[i] && !clr_i[i] && !ack_clr_i[i]) |=> $stable(pend_o[i]));
    end else begin : g_absent
      assign pend_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/lowest_line_pick.sv
module lowest_line_pick
  import irq_arb_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic [NLINES-1:0] req_i,
  output logic [NLINES-1:0] onehot_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);

  // Isolate the lowest set bit: req & -req.
  assign onehot_o = req_i & (~req_i + NLINES'(1));
  assign any_o    = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/ack_vector_unit.sv
module ack_vector_unit
  import irq_arb_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_ack_i,
  input  logic              out_ack_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              in_any_i,
  input  logic [IDX_W-1:0]  in_idx_i,
  input  logic [NLINES-1:0] in_onehot_i,
  input  logic              out_any_i,
  input  logic [IDX_W-1:0]  out_idx_i,
  input  logic [NLINES-1:0] out_onehot_i,
  output logic [NLINES-1:0] in_clr_o,
  output logic [NLINES-1:0] out_clr_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o
);

  ack_kind_e        kind;
  logic [VEC_W-1:0] vec_d;

  // Input side has priority when both strobes coincide.
  always_comb begin
    if (in_ack_i)       kind = ACK_IN;
    else if (out_ack_i) kind = ACK_OUT;
    else                kind = ACK_NONE;
  end

  assign in_clr_o  = (kind == ACK_IN)  ? in_onehot_i  : '0;
  assign out_clr_o = (kind == ACK_OUT) ? out_onehot_i : '0;

  always_comb begin
    unique case (kind)
      ACK_IN:  vec_d = in_any_i  ? vec_calc(base_i, in_idx_i, 1'b0)  : '0;
      ACK_OUT: vec_d = out_any_i ? vec_calc(base_i, out_idx_i, 1'b1) : '0;
      default: vec_d = vec_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_o       <= vec_d;
      vec_valid_o <= (kind != ACK_NONE);
    end
  end

  // R3: every acknowledge yields a valid pulse
  p_valid_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack_i || out_ack_i) |=> vec_valid_o);

  // R12: no acknowledge, no valid, vector held
  p_valid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ack_i || out_ack_i) |=> (!vec_valid_o && $stable(vec_o)));

  // R6: empty side returns zero
  p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack_i && !in_any_i) |=> (vec_o == '0));

  // R3: input vectors sit on an 8-byte slot of the aligned base
  p_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack_i && in_any_i) |=>
      (((vec_o - aligned_base($past(base_i))) & VEC_W'(7)) == VEC_W'(0)));

  // R5: output vectors sit 4 above the slot
  p_out_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ack_i && !in_ack_i && out_any_i) |=>
      (((vec_o - aligned_base($past(base_i))) & VEC_W'(7)) == VEC_W'(4)));

  // R10: at most one line of one side is cleared per cycle
  p_single_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_clr_o, out_clr_o}));

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NLINES       = 16,
  parameter int ACTIVE_LINES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] rx_set,
  input  logic [NLINES-1:0] rx_clr,
  input  logic [NLINES-1:0] ds_set,
  input  logic [NLINES-1:0] ds_clr,
  input  logic [NLINES-1:0] tx_set,
  input  logic [NLINES-1:0] tx_clr,
  input  logic [8:0]        vec_base,
  input  logic              in_ack,
  input  logic              out_ack,
  output logic              in_irq,
  output logic              out_irq,
  output logic [9:0]        vec_out,
  output logic              vec_valid
);

  localparam logic [NLINES-1:0] ACT_MASK = (ACTIVE_LINES >= NLINES) ? '1 :
                                           NLINES'((64'd1 << ACTIVE_LINES) - 64'd1);

  logic [NLINES-1:0] rx_pend, ds_pend, tx_pend;
  logic [NLINES-1:0] in_req;
  logic [NLINES-1:0] in_onehot, out_onehot;
  logic [IDX_W-1:0]  in_idx, out_idx;
  logic              in_any, out_any;
  logic [NLINES-1:0] in_clr, out_clr;

  irq_req_bank #(.NLINES(NLINES), .ACTIVE_LINES(ACTIVE_LINES)) u_rx_bank (
    .clk(clk), .rst_n(rst_n), .set_i(rx_set), .clr_i(rx_clr),
    .ack_clr_i(in_clr), .pend_o(rx_pend));

  irq_req_bank #(.NLINES(NLINES), .ACTIVE_LINES(ACTIVE_LINES)) u_ds_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ds_set), .clr_i(ds_clr),
    .ack_clr_i(in_clr), .pend_o(ds_pend));

  irq_req_bank #(.NLINES(NLINES), .ACTIVE_LINES(ACTIVE_LINES)) u_tx_bank (
    .clk(clk), .rst_n(rst_n), .set_i(tx_set), .clr_i(tx_clr),
    .ack_clr_i(out_clr), .pend_o(tx_pend));

  assign in_req = rx_pend | ds_pend;

  lowest_line_pick #(.NLINES(NLINES)) u_in_pick (
    .req_i(in_req), .onehot_o(in_onehot), .idx_o(in_idx), .any_o(in_any));

  lowest_line_pick #(.NLINES(NLINES)) u_out_pick (
    .req_i(tx_pend), .onehot_o(out_onehot), .idx_o(out_idx), .any_o(out_any));

  ack_vector_unit #(.NLINES(NLINES)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .in_ack_i(in_ack), .out_ack_i(out_ack), .base_i(vec_base),
    .in_any_i(in_any), .in_idx_i(in_idx), .in_onehot_i(in_onehot),
    .out_any_i(out_any), .out_idx_i(out_idx), .out_onehot_i(out_onehot),
    .in_clr_o(in_clr), .out_clr_o(out_clr),
    .vec_o(vec_out), .vec_valid_o(vec_valid));

  assign in_irq  = in_any;
  assign out_irq = out_any;

  // R2: a set on a live line without an input acknowledge raises in_irq
  p_in_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|((rx_set | ds_set) & ACT_MASK)) && !in_ack) |=> in_irq);

  // R2: transmit set without output service raises out_irq
  p_out_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(tx_set & ACT_MASK)) && !out_ack) |=> out_irq);

  // R7: sets on absent lines cannot wake an idle input side
  p_absent_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_irq && !(|((rx_set | ds_set) & ACT_MASK))) |=> !in_irq);

  // R10: out_ack beside in_ack leaves transmit requests pending
  p_out_deferred_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && out_ack && out_irq && !(|tx_clr)) |=> out_irq);

endmodule

// File: tb/irq_vector_arbiter_test.sv
`timescale 1ns/1ps
module irq_vector_arbiter_test;

  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] rx_set, rx_clr, ds_set, ds_clr, tx_set, tx_clr;
  logic [8:0]    vec_base;
  logic          in_ack, out_ack;
  logic          in_irq, out_irq, vec_valid;
  logic [9:0]    vec_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_vector_arbiter #(.NLINES(NL), .ACTIVE_LINES(12)) uut (
    .clk(clk), .rst_n(rst_n),
    .rx_set(rx_set), .rx_clr(rx_clr), .ds_set(ds_set), .ds_clr(ds_clr),
    .tx_set(tx_set), .tx_clr(tx_clr), .vec_base(vec_base),
    .in_ack(in_ack), .out_ack(out_ack),
    .in_irq(in_irq), .out_irq(out_irq), .vec_out(vec_out), .vec_valid(vec_valid));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expv(input int base, input int line, input bit tx);
    return 32'((base / 4) * 4 + line * 8 + (tx ? 4 : 0));
  endfunction

  task automatic idle_inputs();
    rx_set = '0; rx_clr = '0; ds_set = '0; ds_clr = '0;
    tx_set = '0; tx_clr = '0; in_ack = 1'b0; out_ack = 1'b0;
  endtask

  // Let the driven inputs cross one rising edge, then release them.
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    check("R1", "in_irq", in_irq, 0);
    check("R1", "out_irq", out_irq, 0);
    check("R1", "vec_valid", vec_valid, 0);
    check("R1", "vec_out", vec_out, 0);
  endtask

  task automatic t_priority_drain();
    rx_set[5] = 1'b1; ds_set[2] = 1'b1; step();
    check("R2", "in_irq after set", in_irq, 1);
    check("R2", "out_irq untouched", out_irq, 0);
    in_ack = 1'b1; step();
    check("R3", "vec lowest line2", vec_out, expv(192, 2, 0));
    check("R3", "valid", vec_valid, 1);
    check("R4", "in_irq held by line5", in_irq, 1);
    in_ack = 1'b1; step();
    check("R3", "vec line5", vec_out, expv(192, 5, 0));
    check("R4", "in_irq drained", in_irq, 0);
    step();
    check("R12", "valid drops", vec_valid, 0);
    check("R12", "vec held", vec_out, expv(192, 5, 0));
  endtask

  task automatic t_shared_slot();
    rx_set[3] = 1'b1; ds_set[3] = 1'b1; step();
    in_ack = 1'b1; step();
    check("R4", "shared vec line3", vec_out, expv(192, 3, 0));
    check("R4", "both bits cleared", in_irq, 0);
    in_ack = 1'b1; step();
    check("R6", "empty in vec", vec_out, 0);
    check("R6", "empty valid", vec_valid, 1);
    out_ack = 1'b1; step();
    check("R6", "empty out vec", vec_out, 0);
  endtask

  task automatic t_transmit();
    tx_set[7] = 1'b1; tx_set[1] = 1'b1; rx_set[0] = 1'b1; step();
    check("R2", "out_irq", out_irq, 1);
    out_ack = 1'b1; step();
    check("R5", "tx vec line1", vec_out, expv(192, 1, 1));
    check("R5", "out_irq held", out_irq, 1);
    check("R5", "input untouched", in_irq, 1);
    out_ack = 1'b1; step();
    check("R5", "tx vec line7", vec_out, expv(192, 7, 1));
    check("R5", "out_irq drained", out_irq, 0);
    in_ack = 1'b1; step();
    check("R5", "rx line0 survived", vec_out, expv(192, 0, 0));
    check("R4", "in_irq drained", in_irq, 0);
  endtask

  task automatic t_absent_lines();
    rx_set[12] = 1'b1; ds_set[13] = 1'b1; tx_set[15] = 1'b1; step();
    check("R7", "in_irq", in_irq, 0);
    check("R7", "out_irq", out_irq, 0);
    in_ack = 1'b1; step();
    check("R7", "in vec zero", vec_out, 0);
  endtask

  task automatic t_set_vs_clear();
    rx_set[4] = 1'b1; rx_clr[4] = 1'b1; step();
    check("R8", "set beats clear", in_irq, 1);
    rx_clr[4] = 1'b1; step();
    check("R8", "clear alone", in_irq, 0);
  endtask

  task automatic t_ack_collision();
    rx_set[2] = 1'b1; step();
    in_ack = 1'b1; rx_set[2] = 1'b1; rx_set[6] = 1'b1; step();
    check("R9", "vec line2", vec_out, expv(192, 2, 0));
    check("R9", "line6 kept", in_irq, 1);
    in_ack = 1'b1; step();
    check("R9", "next is line6", vec_out, expv(192, 6, 0));
    check("R9", "line2 set lost", in_irq, 0);
  endtask

  task automatic t_both_acks();
    rx_set[1] = 1'b1; tx_set[0] = 1'b1; step();
    in_ack = 1'b1; out_ack = 1'b1; step();
    check("R10", "input served", vec_out, expv(192, 1, 0));
    check("R10", "tx kept", out_irq, 1);
    out_ack = 1'b1; step();
    check("R10", "tx served later", vec_out, expv(192, 0, 1));
    check("R10", "out drained", out_irq, 0);
  endtask

  task automatic t_base_align();
    vec_base = 9'h1FF;
    tx_set[11] = 1'b1; ds_set[11] = 1'b1; step();
    out_ack = 1'b1; step();
    check("R11", "tx vec odd base", vec_out, expv(511, 11, 1));
    in_ack = 1'b1; step();
    check("R11", "in vec odd base", vec_out, expv(511, 11, 0));
    vec_base = 9'h0C0;
  endtask

  initial begin
    idle_inputs();
    vec_base = 9'h0C0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_priority_drain();
    t_shared_slot();
    t_transmit();
    t_absent_lines();
    t_set_vs_clear();
    t_ack_collision();
    t_both_acks();
    t_base_align();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule